// File: doc/BRIEF.md
# Asymmetric Video-Presence Delay Qualifier

This block turns a raw video-present indication into a qualified video status and an RF mute request. Video has to stay present for a short qualification interval before the status goes true. It has to stay absent for a much longer interval before the status goes false again. Each interval is timed by its own tick-driven counter, and each counter has its own prescaler, so the two windows can sit at very different lengths while sharing one slow tick strobe.

While a loss is being timed, a level-reduce output lowers the transmitted level without muting it. An override input disables both timers and passes the raw video indication straight to the mute path. Three frequency-unlock inputs are combined into an active-low locked indication. The mute request is raised when any unlock is present or when qualified video is absent.

Top module: `vid_delay_qual`

## Requirements
- R1: While reset is applied, and on leaving reset, vid_ok is 0 and rf_mute is 1, so the output stays muted until video has been qualified.
- R2: In normal mode (override = 0), vid_ok rises at the clock edge that samples the PRESENT_TC*PRESENT_DIV-th tick_en pulse while vid_present has been 1 continuously.
- R3: A cycle with vid_present = 0 clears the present timer, so qualification afterwards needs the full PRESENT_TC*PRESENT_DIV ticks again.
- R4: In normal mode, vid_ok falls at the clock edge that samples the LOSS_TC*LOSS_DIV-th tick_en pulse while vid_present has been 0 continuously.
- R5: The loss timer is held cleared while vid_present is 1, so a dropout lasting fewer than LOSS_TC*LOSS_DIV ticks never clears vid_ok.
- R6: level_cut is 1 exactly when override is 0, vid_present is 0 and the loss timer has not yet completed; otherwise it is 0.
- R7: Both timers advance only on cycles with tick_en = 1; cycles with tick_en = 0 leave them unchanged.
- R8: With override = 1, both timers are held cleared, the status flag is cleared, vid_ok follows vid_present directly and level_cut is 0; after override returns to 0, video must be qualified again.
- R9: lock_n is 0 when any bit of unlock is 1 and 1 otherwise; rf_mute is 1 when any bit of unlock is 1 or vid_ok is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Single-cycle timing strobe that advances the timers |
| vid_present | input | 1 | Raw video-present indication, 1 = video seen |
| override | input | 1 | 1 = bypass both timers and pass the raw indication through |
| unlock | input | N_LOCK | Frequency-unlock flags, 1 = that source is unlocked |
| vid_ok | output | 1 | Qualified video-present status |
| level_cut | output | 1 | Reduced-level request while a loss is being timed |
| lock_n | output | 1 | Active-low all-sources-locked indication |
| rf_mute | output | 1 | RF mute request |

## Verification
The bench targets the exact tick at which each timer completes. A design off by one in the terminal count or prescaler would move the vid_ok edge by a cycle. A short dropout during qualification has to restart the present count; a design that only paused that count would qualify early. A dropout shorter than the loss window must leave vid_ok high, and a design that kept the loss count across video returns would drop the status too soon. The bench also sparses the tick strobe, toggles override around a qualified state, and drives each unlock bit alone. A design that counted cycles instead of ticks, kept the flag through override, or missed an unlock source would show the wrong status, level or mute.

// File: rtl/vdq_pkg.sv
package vdq_pkg;

  // Width needed to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((2 ** w) <= max_val) w++;
    return w;
  endfunction

  // Bundle of externally visible status bits
  typedef struct packed {
    logic vid_ok;
    logic level_cut;
    logic lock_n;
    logic rf_mute;
  } vdq_status_t;

endpackage

// File: rtl/vdq_tick_timer.sv
module vdq_tick_timer
  import vdq_pkg::*;
#(
  parameter int unsigned TC  = 32768,
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick_en,
  output logic done_pulse,
  output logic expired
);

  localparam int unsigned CW = cnt_width(TC);
  localparam logic [CW-1:0] TC_V   = CW'(TC);
  localparam logic [CW-1:0] LAST_V = CW'(TC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          full;
  logic          step_ok;
  logic          adv;

  assign full    = (cnt_q == TC_V);
  assign step_ok = tick_en && !clr && !full;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign adv = step_ok;
    end else begin : g_div
      localparam int unsigned PW = cnt_width(DIV - 1);
      localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;
      logic [PW-1:0] pre_d;
      logic          pre_wrap;

      assign pre_wrap = (pre_q == PRE_LAST);
      assign adv      = step_ok && pre_wrap;

      always_comb begin
        pre_d = pre_q;
        if (clr) begin
          pre_d = '0;
        end else if (step_ok) begin
          if (pre_wrap) pre_d = '0;
          else          pre_d = pre_q + PW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_pulse = adv && (cnt_q == LAST_V);
  assign expired    = full;

  // Completion leaves the timer saturated at its terminal count
  assert_done_then_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> expired);

  // Without a tick and without a clear, the count does not move
  assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> $stable(cnt_q));

  // A clear always empties the timer by the next cycle
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expired);

endmodule

// File: rtl/vdq_status_flag.sv
module vdq_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic clr_p,
  input  logic force_clr,
  output logic flag
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (force_clr)  flag_d = 1'b0;
    else if (clr_p) flag_d = 1'b0;
    else if (set_p) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_p && !force_clr && !clr_p) |=> flag);

  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> !flag);

endmodule

// File: rtl/vdq_mute_combine.sv
module vdq_mute_combine
  import vdq_pkg::*;
#(
  parameter int unsigned N_LOCK = 3
) (
  input  logic              flag,
  input  logic              vid_present,
  input  logic              override,
  input  logic              loss_expired,
  input  logic [N_LOCK-1:0] unlock,
  output vdq_status_t       status
);

  logic [N_LOCK:0] any_chain;
  logic            vid_q_sel;

  assign any_chain[0] = 1'b0;
  generate
    for (genvar i = 0; i < N_LOCK; i++) begin : g_unlock
      assign any_chain[i+1] = any_chain[i] | unlock[i];
    end
  endgenerate

  assign vid_q_sel = override ? vid_present : flag;

  always_comb begin
    status.vid_ok    = vid_q_sel;
    status.level_cut = !override && !vid_present && !loss_expired;
    status.lock_n    = !any_chain[N_LOCK];
    status.rf_mute   = any_chain[N_LOCK] || !vid_q_sel;
  end

endmodule

// File: rtl/vid_delay_qual.sv
module vid_delay_qual
  import vdq_pkg::*;
#(
  parameter int unsigned PRESENT_TC  = 32768,
  parameter int unsigned PRESENT_DIV = 1,
  parameter int unsigned LOSS_TC     = 32768,
  parameter int unsigned LOSS_DIV    = 16,
  parameter int unsigned N_LOCK      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              vid_present,
  input  logic              override,
  input  logic [N_LOCK-1:0] unlock,
  output logic              vid_ok,
  output logic              level_cut,
  output logic              lock_n,
  output logic              rf_mute
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic        pres_clr;
  logic        loss_clr;
  logic        pres_done;
  logic        pres_full;
  logic        loss_done;
  logic        loss_full;
  logic        vid_flag;
  vdq_status_t status;

  // Present timer runs only while video is seen; loss timer only while it is not
  assign pres_clr = override || !vid_present;
  assign loss_clr = override ||  vid_present;

  vdq_tick_timer #(
    .TC  (PRESENT_TC),
    .DIV (PRESENT_DIV)
  ) u_pres_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (pres_clr),
    .tick_en    (tick_en),
    .done_pulse (pres_done),
    .expired    (pres_full)
  );

  vdq_tick_timer #(
    .TC  (LOSS_TC),
    .DIV (LOSS_DIV)
  ) u_loss_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (loss_clr),
    .tick_en    (tick_en),
    .done_pulse (loss_done),
    .expired    (loss_full)
  );

  vdq_status_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_p     (pres_done),
    .clr_p     (loss_done),
    .force_clr (override),
    .flag      (vid_flag)
  );

  vdq_mute_combine #(
    .N_LOCK (N_LOCK)
  ) u_combine (
    .flag         (vid_flag),
    .vid_present  (vid_present),
    .override     (override),
    .loss_expired (loss_full),
    .unlock       (unlock),
    .status       (status)
  );

  assign vid_ok    = status.vid_ok;
  assign level_cut = status.level_cut;
  assign lock_n    = status.lock_n;
  assign rf_mute   = status.rf_mute;

  // The qualified flag only rises on a present-timer completion
  assert_flag_rise_source_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(vid_flag) |-> $past(pres_done));

  // A present timer that is saturated never coexists with a running loss count
  assert_pres_full_needs_video_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    pres_full |-> $past(vid_present && !override));

  // While video is seen in normal mode, the status cannot fall
  assert_no_drop_while_present_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vid_present && !override) |=> !$fell(vid_flag));

  // Level reduction never accompanies seen video or override
  assert_level_quiet_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vid_present || override) |-> !level_cut);

  // Override forgets any earlier qualification
  assert_override_clears_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    override |=> !vid_flag);

  // Any unlock forces the mute and drops the locked indication
  assert_unlock_mutes_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|unlock) |-> (rf_mute && !lock_n));

  // Coming out of reset the output is muted
  assert_reset_muted_R1: assert property (@(posedge clk)
    !rst_int_n |-> (rf_mute && !vid_ok));

endmodule

// File: tb/vid_delay_qual_tb.sv
`timescale 1ns/1ps
module vid_delay_qual_tb;

  localparam int unsigned PTC  = 6;
  localparam int unsigned PDIV = 2;
  localparam int unsigned LTC  = 10;
  localparam int unsigned LDIV = 3;
  localparam int unsigned PT_FULL = PTC * PDIV;
  localparam int unsigned LT_FULL = LTC * LDIV;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       vid_present;
  logic       override;
  logic [2:0] unlock;
  logic       vid_ok;
  logic       level_cut;
  logic       lock_n;
  logic       rf_mute;

  int checks;
  int fails;
  bit done;

  sb_item_t sbq[$];

  // Requirement-level model state
  int  m_pt;
  int  m_lt;
  bit  m_flag;

  vid_delay_qual #(
    .PRESENT_TC  (PTC),
    .PRESENT_DIV (PDIV),
    .LOSS_TC     (LTC),
    .LOSS_DIV    (LDIV),
    .N_LOCK      (3)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .vid_present (vid_present),
    .override    (override),
    .unlock      (unlock),
    .vid_ok      (vid_ok),
    .level_cut   (level_cut),
    .lock_n      (lock_n),
    .rf_mute     (rf_mute)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [3:0] expect_now();
    logic ok;
    logic lc;
    ok = override ? vid_present : m_flag;
    lc = !override && !vid_present && (m_lt < LT_FULL);
    return {ok, lc, ~(|unlock), (|unlock) | ~ok};
  endfunction

  // Driver: advance the model with the inputs the design just sampled,
  // then apply new inputs and queue the expected outputs
  task automatic step(input logic v, input logic o, input logic t,
                      input logic [2:0] u, input string tag);
    sb_item_t it;
    @(posedge clk);
    if (override) begin
      m_pt = 0; m_lt = 0; m_flag = 1'b0;
    end else if (vid_present) begin
      m_lt = 0;
      if (tick_en && m_pt < PT_FULL) begin
        m_pt++;
        if (m_pt == PT_FULL) m_flag = 1'b1;
      end
    end else begin
      m_pt = 0;
      if (tick_en && m_lt < LT_FULL) begin
        m_lt++;
        if (m_lt == LT_FULL) m_flag = 1'b0;
      end
    end
    #1;
    vid_present = v;
    override    = o;
    tick_en     = t;
    unlock      = u;
    it.exp = expect_now();
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic run(input int n, input logic v, input logic o, input int tick_every,
                     input logic [2:0] u, input string tag);
    for (int i = 0; i < n; i++) begin
      step(v, o, (tick_every > 0) && ((i % tick_every) == 0), u, tag);
    end
  endtask

  // Monitor: compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sb_item_t it;
      logic [3:0] act;
      it  = sbq.pop_front();
      act = {vid_ok, level_cut, lock_n, rf_mute};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: {vid_ok,level_cut,lock_n,rf_mute} actual=%b expected=%b at %0t",
                 it.tag, act, it.exp, $time);
      end
    end
  end

  task automatic direct_check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {vid_ok, level_cut, lock_n, rf_mute};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {vid_ok,level_cut,lock_n,rf_mute} actual=%b expected=%b",
               tag, act, exp);
    end
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    m_pt = 0; m_lt = 0; m_flag = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; vid_present = 1'b0;
    override = 1'b0; unlock = 3'b000;

    // R1: reset state, video absent, no unlock
    repeat (3) @(negedge clk);
    direct_check(4'b0111, "R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    run(4, 1'b0, 1'b0, 0, 3'b000, "R1 after reset");

    // R6: loss window timed from reset, level_cut until completion
    run(LT_FULL + 4, 1'b0, 1'b0, 1, 3'b000, "R6 loss timing from idle");

    // R3: partial present count then a dropout restarts it
    run(PT_FULL - 2, 1'b1, 1'b0, 1, 3'b000, "R3 partial present");
    run(2, 1'b0, 1'b0, 1, 3'b000, "R3 dropout");
    // R2: full present count from scratch
    run(PT_FULL + 3, 1'b1, 1'b0, 1, 3'b000, "R2 present qualify");

    // R5: dropouts shorter than the loss window keep vid_ok
    run(10, 1'b0, 1'b0, 1, 3'b000, "R5 short dropout");
    run(3, 1'b1, 1'b0, 1, 3'b000, "R5 video back");
    run(LT_FULL - 3, 1'b0, 1'b0, 1, 3'b000, "R5 near-window dropout");
    run(2, 1'b1, 1'b0, 1, 3'b000, "R5 video back again");

    // R4: long loss clears the status at the exact tick
    run(LT_FULL + 3, 1'b0, 1'b0, 1, 3'b000, "R4 loss qualify");

    // R7: sparse ticks stretch qualification to whole ticks only
    run(PT_FULL * 3 + 6, 1'b1, 1'b0, 3, 3'b000, "R7 sparse ticks present");
    run(LT_FULL * 2, 1'b0, 1'b0, 2, 3'b000, "R7 sparse ticks loss");
    run(PT_FULL + 1, 1'b1, 1'b0, 1, 3'b000, "R7 requalify");

    // R9: each unlock alone, all, then none
    run(2, 1'b1, 1'b0, 1, 3'b001, "R9 unlock bit0");
    run(2, 1'b1, 1'b0, 1, 3'b010, "R9 unlock bit1");
    run(2, 1'b1, 1'b0, 1, 3'b100, "R9 unlock bit2");
    run(2, 1'b1, 1'b0, 1, 3'b111, "R9 unlock all");
    run(2, 1'b1, 1'b0, 1, 3'b000, "R9 all locked");

    // R8: override passes raw video through and drops qualification
    run(3, 1'b1, 1'b1, 1, 3'b000, "R8 override present");
    run(3, 1'b0, 1'b1, 1, 3'b000, "R8 override absent");
    run(2, 1'b1, 1'b1, 1, 3'b010, "R8 override with unlock");
    run(PT_FULL - 1, 1'b1, 1'b0, 1, 3'b000, "R8 requalify needed");
    run(3, 1'b1, 1'b0, 1, 3'b000, "R8 requalified");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule